// File: doc/BRIEF.md
# Countdown System Event Timer

A single-channel, 32-bit down-counter that produces one interrupt per programmed delay. Software sets the run enable in the control word, then writes a tick count into the count register. That write loads the counter and starts the countdown. Each cycle in which the `tick` input is high moves the count one step toward zero. When the count reaches zero a pending flag is raised. The interrupt line shows that flag whenever the interrupt mask bit is set.

The run enable gates every change of state. While it is low the count is frozen, count-register writes are dropped and the pending flag cannot change. Writing zero to the control word therefore stops the timer completely. A pending interrupt is removed by a control write that sets both the clear bit and the run enable. The smallest delay the driver is expected to program is 3 ticks, and the largest is 0xFFFFFFFF.

Internally a three-state machine tracks the counter:
- ST_IDLE: nothing is armed.
- ST_RUN: the counter is counting down.
- ST_FIRED: the count has reached zero.

Its transitions are:
- IDLE→RUN, RUN→RUN and FIRED→RUN: arm, on a non-zero load.
- RUN→FIRED: last tick, when the count steps from 1 to 0.
- RUN→IDLE and FIRED→IDLE: disarm, on a zero load.
- FIRED→IDLE: acknowledge, on an effective clear.

Top module: `sys_event_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 and `irq` is low.
- R2: The control word is at address 0x40. Bit 0 is the run enable and bit 1 is the interrupt mask, and both read back as written. Bit 4 is the clear request, which reads back as 0. All other bits read as 0.
- R3: A write to the count register at 0x44 while the stored run enable is 1 loads the full 32-bit value. A read of 0x44 returns the current count.
- R4: A write to 0x44 while the stored run enable is 0 leaves the count unchanged.
- R5: While enabled and non-zero, the count drops by exactly one in each cycle with `tick` high. It does not change in cycles without `tick`.
- R6: The tick that takes the count from 1 to 0 sets the pending flag. Further ticks leave the count at 0.
- R7: `irq` equals the pending flag ANDed with the interrupt mask bit.
- R8: A control write clears the pending flag only when bit 4 and bit 0 are both 1 in that same written word. Otherwise the flag is unchanged.
- R9: While the run enable is 0, ticks do not move the count. Writing 0 to the control word freezes the count and the pending flag until the timer is enabled again.
- R10: When an expiring tick coincides with an effective clear, the expiry wins and the flag ends set. When a tick coincides with a count load, the load wins.
- R11: Loading 0 leaves the counter idle at 0 and raises no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick | input | 1 | Count-step strobe |
| irq | output | 1 | Interrupt request |

## Verification
The delicate collision is an acknowledge write (clear plus enable) landing in the same cycle as the tick that takes the count from 1 to 0. A second, similar collision is a count load arriving together with a tick. The bench arms a short count, steps it to 1, and then issues the clear and the tick on one clock edge. It expects `irq` to stay high, because a fresh expiry must not be lost. For the other collision it writes a new count with `tick` high and expects the loaded value, with no decrement, to read back.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    parameter int CNT_W  = 32;
    parameter int ADDR_W = 8;

    localparam int BIT_RUN  = 0;
    localparam int BIT_MASK = 1;
    localparam int BIT_CLR  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FIRED = 2'd2
    } cd_state_t;
endpackage

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
    import evt_timer_pkg::*;
#(
    parameter int            AW       = ADDR_W,
    parameter int            DW       = CNT_W,
    parameter logic [AW-1:0] CTRL_ADR = 'h40,
    parameter logic [AW-1:0] CNT_ADR  = 'h44
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          run_en,
    output logic          mask_en,
    output logic          clr_req,
    output logic          load_req,
    output logic          ctrl_hit
);
    logic wr_ctrl;

    assign wr_ctrl  = sel && we && (addr == CTRL_ADR);
    assign ctrl_hit = (addr == CTRL_ADR);
    assign clr_req  = wr_ctrl && wdata[BIT_CLR] && wdata[BIT_RUN];
    assign load_req = sel && we && (addr == CNT_ADR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            mask_en <= 1'b0;
        end else if (wr_ctrl) begin
            run_en  <= wdata[BIT_RUN];
            mask_en <= wdata[BIT_MASK];
        end
    end

    AST_CLR_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> run_en); // R8
endmodule

// File: rtl/evt_countdown.sv
module evt_countdown
    import evt_timer_pkg::*;
#(
    parameter int DW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          load_req,
    input  logic [DW-1:0] load_val,
    input  logic          clr_req,
    input  logic          tick,
    output logic [DW-1:0] count,
    output logic          pending
);
    localparam logic [DW-1:0] ONE = DW'(1);

    cd_state_t     state_q, state_d;
    logic [DW-1:0] count_d;
    logic          pend_d;
    logic          do_load, do_step, last_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count   <= '0;
            pending <= 1'b0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
            pending <= pend_d;
        end
    end

    always_comb begin
        do_load   = run_en && load_req;
        do_step   = run_en && !load_req && tick && (state_q == ST_RUN);
        last_step = do_step && (count == ONE);
        state_d   = state_q;
        count_d   = count;
        pend_d    = pending;
        if (last_step)    pend_d = 1'b1;
        else if (clr_req) pend_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (do_load) begin
                    count_d = load_val;
                    state_d = (load_val != '0) ? ST_RUN : ST_IDLE;
                end
            end
            ST_RUN: begin
                if (do_load) begin
                    count_d = load_val;
                    state_d = (load_val != '0) ? ST_RUN : ST_IDLE;
                end else if (do_step) begin
                    count_d = count - ONE;
                    if (last_step) state_d = ST_FIRED;
                end
            end
            ST_FIRED: begin
                if (do_load) begin
                    count_d = load_val;
                    state_d = (load_val != '0) ? ST_RUN : ST_IDLE;
                end else if (clr_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && load_req) |=> (count == $past(load_val))); // R3
    AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(count)); // R9
    AST_FROZEN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clr_req) |=> $stable(pending)); // R9
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_req && tick && state_q == ST_RUN && count == ONE)
        |=> (pending && count == '0)); // R6
    AST_FIRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRED) |-> (count == '0)); // R6
endmodule

// File: rtl/sys_event_timer.sv
module sys_event_timer
    import evt_timer_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick,
    output logic          irq
);
    localparam logic [AW-1:0] CTRL_ADR = AW'('h40);
    localparam logic [AW-1:0] CNT_ADR  = AW'('h44);

    logic          run_en, mask_en, clr_req, load_req, ctrl_hit, pending;
    logic [DW-1:0] count;
    logic [DW-1:0] ctrl_word;

    evt_ctrl_regs #(.AW(AW), .DW(DW), .CTRL_ADR(CTRL_ADR), .CNT_ADR(CNT_ADR)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .run_en(run_en), .mask_en(mask_en), .clr_req(clr_req),
        .load_req(load_req), .ctrl_hit(ctrl_hit)
    );

    evt_countdown #(.DW(DW)) u_cd (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .load_req(load_req),
        .load_val(bus_wdata), .clr_req(clr_req), .tick(tick),
        .count(count), .pending(pending)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_RUN]  = run_en;
        ctrl_word[BIT_MASK] = mask_en;
        if (ctrl_hit)                bus_rdata = ctrl_word;
        else if (bus_addr == CNT_ADR) bus_rdata = count;
        else                          bus_rdata = '0;
    end

    assign irq = pending && mask_en;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == CTRL_ADR && !bus_wdata[BIT_MASK]) |=> !irq); // R7
endmodule

// File: tb/sim_sys_event_timer.sv
`timescale 1ns/1ps
module sim_sys_event_timer;
    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0, tick = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          total = 0, bad = 0;
    bit          done = 0;

    localparam logic [7:0] A_CTRL = 8'h40, A_CNT = 8'h44;

    sys_event_timer u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .irq(irq));

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_cnt(input logic [31:0] v, input int k);
        return (v > k) ? v - k : 32'd0;
    endfunction
    function automatic logic exp_irq(input logic [31:0] v, input int k);
        return (v != 0) && (k >= v);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; tick = t;
        @(posedge clk); #2;
        bus_sel = 0; bus_we = 0; tick = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 0, A_CNT, 0, 1);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        process::self().srandom(32'd7);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(A_CNT, r);  chk("R1 count", r, 0);
        rd(A_CTRL, r); chk("R1 ctrl", r, 0);
        chk("R1 irq", irq, 0);
        // R4 load ignored when disabled
        wr(A_CNT, 32'd10); rd(A_CNT, r); chk("R4 load gated", r, 0);
        // R2 control readback, clear bit reads 0
        wr(A_CTRL, 32'hFFFF_FFEF & 32'h13 | 32'h3); rd(A_CTRL, r); chk("R2 ctrl readback", r, 32'h3);
        // R3 load
        wr(A_CNT, 32'd5); rd(A_CNT, r); chk("R3 load", r, 5);
        // R5 no change without tick
        repeat (4) step(0, 0, A_CNT, 0, 0);
        rd(A_CNT, r); chk("R5 no tick hold", r, 5);
        ticks(4); rd(A_CNT, r); chk("R5 decrement", r, 1);
        chk("R6 not yet", irq, 0);
        ticks(1); rd(A_CNT, r); chk("R6 zero", r, 0);
        chk("R6 fired", irq, 1);
        ticks(3); rd(A_CNT, r); chk("R6 stays zero", r, 0);
        // R7 masking
        wr(A_CTRL, 32'h1); chk("R7 masked", irq, 0);
        wr(A_CTRL, 32'h3); chk("R7 unmasked", irq, 1);
        // R8 clear without run bit is ignored
        wr(A_CTRL, 32'h12); chk("R8 clr ignored", irq, 1);
        wr(A_CTRL, 32'h13); chk("R8 clr works", irq, 0);
        rd(A_CTRL, r); chk("R2 clr reads 0", r, 32'h3);
        // R9 stop freezes
        wr(A_CNT, 32'd8); ticks(2);
        wr(A_CTRL, 32'h0); ticks(3);
        rd(A_CNT, r); chk("R9 frozen", r, 6);
        wr(A_CTRL, 32'h3); ticks(6);
        rd(A_CNT, r); chk("R9 resumed", r, 0);
        chk("R9 resumed irq", irq, 1);
        // R10 expiry beats clear
        wr(A_CTRL, 32'h13);
        wr(A_CNT, 32'd3); ticks(2);
        step(1, 1, A_CTRL, 32'h13, 1);
        chk("R10 expiry wins", irq, 1);
        // R10 load beats tick
        wr(A_CTRL, 32'h13);
        step(1, 1, A_CNT, 32'd7, 1);
        rd(A_CNT, r); chk("R10 load wins", r, 7);
        // R11 load zero
        wr(A_CNT, 32'd0); ticks(2);
        rd(A_CNT, r); chk("R11 zero count", r, 0);
        chk("R11 no irq", irq, 0);
        // R3 full width
        wr(A_CNT, 32'hFFFF_FFFF); rd(A_CNT, r); chk("R3 max", r, 32'hFFFF_FFFF);
        ticks(1); rd(A_CNT, r); chk("R5 max step", r, 32'hFFFF_FFFE);
        // random: R5 R6 R7
        for (int it = 0; it < 30; it++) begin
            logic [31:0] v;
            int k, goal;
            v = 32'd3 + ($urandom % 48);
            goal = $urandom % (v + 4);
            k = 0;
            wr(A_CTRL, 32'h13);
            wr(A_CNT, v);
            while (k < goal) begin
                if ($urandom % 3 != 0) begin ticks(1); k++; end
                else step(0, 0, A_CNT, 0, 0);
            end
            rd(A_CNT, r); chk("R5 random count", r, exp_cnt(v, k));
            chk("R6 random irq", irq, exp_irq(v, k));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule